// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces every timing strobe a flat panel needs from one LCD/memory clock (LCLK). A programmable divider makes a one-cycle pixel enable. Two position counters advance on that enable. The horizontal counter walks through a line, and the vertical counter walks through a frame. From their positions the block decodes the line sync (HSYNC), the frame sync (VSYNC) and a data-active flag. Pixel data, palette lookup and memory fetch are left to the blocks around it.

A line is laid out in pixel clocks in this order: the HSYNC pulse, the leading wait states, the visible pixels, then the trailing wait states. A frame is laid out in lines in the same way: the sync interval, the leading inserted lines, the visible lines, then the trailing inserted lines. In active-matrix mode the sync interval drives VSYNC high. In passive mode the same lines are only inserted blank, and VSYNC marks the first visible line instead. All settings are copied into shadow registers at reset and at each frame boundary, so a change made mid-frame never tears the current frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: `pix_en_o` is a single-cycle pulse with a period of exactly 2·(N+1) LCLK cycles, where N is the shadowed divisor `cfg_pcd`. After reset the first pulse comes 2·(N+1)−1 cycles after release.
- R2: When `cfg_dbl_pix` is 1 and `cfg_pcd` is 0, the divisor is treated as 1, which gives a period of 4 cycles.
- R3: `hsync_o` is high for the first `cfg_hsw`+1 pixel clocks of every line and low for the rest of the line.
- R4: A line lasts (`cfg_hsw`+1) + `cfg_hbp` + (`cfg_ppl`+1) + `cfg_hfp` pixel clocks. `de_o` can only be high in the `cfg_ppl`+1 pixel clocks that follow the sync pulse and the `cfg_hbp` leading wait states.
- R5: A frame lasts (`cfg_vsw`+1) + `cfg_vbp` + (`cfg_lpf`+1) + `cfg_vfp` lines. `de_o` is high exactly when both the horizontal and the vertical positions are inside their visible windows.
- R6: In active mode (`cfg_passive`=0), `vsync_o` is high for the first `cfg_vsw`+1 lines of every frame.
- R7: In passive mode (`cfg_passive`=1), `vsync_o` stays low during the `cfg_vsw`+1 inserted sync lines and is high only during the first visible line.
- R8: Changes on any `cfg_*` input take effect only at the pixel clock that ends a frame. The frame in progress keeps its old geometry and divisor.
- R9: While `rst` is high, all four outputs are low. Release starts a new frame at line 0, pixel 0, using the configuration present at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD/memory clock (LCLK) |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pcd | input | 8 | Pixel clock divisor N |
| cfg_dbl_pix | input | 1 | Double pixel clock mode, forces N ≥ 1 |
| cfg_passive | input | 1 | 1 = passive display, 0 = active display |
| cfg_hsw | input | HSW_W | HSYNC width minus one, in pixel clocks |
| cfg_hbp | input | HBP_W | Wait states at line start |
| cfg_ppl | input | PPL_W | Pixels per line minus one |
| cfg_hfp | input | HFP_W | Wait states at line end |
| cfg_vsw | input | VSW_W | Sync interval minus one, in lines |
| cfg_vbp | input | VBP_W | Inserted lines at frame start |
| cfg_lpf | input | LPF_W | Lines per frame minus one |
| cfg_vfp | input | VFP_W | Inserted lines at frame end |
| pix_en_o | output | 1 | Pixel clock enable pulse |
| hsync_o | output | 1 | Line clock |
| vsync_o | output | 1 | Frame clock |
| de_o | output | 1 | Data-active flag |

## Verification
The outputs are decoded combinationally from registered counters. After the clock edge that carries a `pix_en_o` pulse, HSYNC, VSYNC and data-active show the next pixel position; between pulses they hold. The bench therefore samples on the falling edge. It compares the current outputs against a model position, and it advances that position only after a sample in which the pulse was expected. The divider is checked by counting falling edges between pulses, starting from the one at reset release. The configuration inputs are changed only on a falling edge, and the model captures them in the same sample in which it closes a frame, which matches the edge at which the block loads its shadow copy.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int PCD_W = 8;
  localparam int DIV_W = PCD_W + 1;

  typedef enum logic {MODE_ACTIVE = 1'b0, MODE_PASSIVE = 1'b1} lcd_mode_e;

  // divisor actually used: double pixel mode forbids zero
  function automatic logic [PCD_W-1:0] eff_pcd(input logic [PCD_W-1:0] pcd,
                                               input logic dbl);
    return (dbl && pcd == '0) ? PCD_W'(1) : pcd;
  endfunction

  // terminal count of the divider: 2*(N+1)-1 = 2N+1
  function automatic logic [DIV_W-1:0] div_last(input logic [PCD_W-1:0] pcd,
                                                input logic dbl);
    return {eff_pcd(pcd, dbl), 1'b1};
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/lcd_tg_div.sv
module lcd_tg_div
  import lcd_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PCD_W-1:0] pcd,
  input  logic             dbl,
  output logic             pix_en
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last   = div_last(pcd, dbl);
  assign pix_en = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (pix_en) cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end

  a_r1_single_cycle: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> !pix_en);
  a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);
  a_r2_dbl_min_period: assert property (@(posedge clk) disable iff (rst)
    dbl |-> last >= DIV_W'(3));
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int SW = 6,
  parameter int BW = 8,
  parameter int AW = 10,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [SW-1:0] sync_m1,
  input  logic [BW-1:0] back_n,
  input  logic [AW-1:0] act_m1,
  input  logic [FW-1:0] front_n,
  output logic          last,
  output logic          in_sync,
  output logic          in_act,
  output logic          act_first
);
  localparam int MW = max4(SW, BW, AW, FW);
  localparam int TW = MW + 2;

  logic [TW-1:0] pos;
  logic [TW-1:0] s_end, a_beg, a_end, total;

  assign s_end = TW'(sync_m1) + TW'(1);
  assign a_beg = s_end + TW'(back_n);
  assign a_end = a_beg + TW'(act_m1) + TW'(1);
  assign total = a_end + TW'(front_n);

  assign last      = (pos == total - TW'(1));
  assign in_sync   = (pos < s_end);
  assign in_act    = (pos >= a_beg) && (pos < a_end);
  assign act_first = (pos == a_beg);

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (step) pos <= last ? '0 : pos + TW'(1);
  end

  a_r4_pos_bounded: assert property (@(posedge clk) disable iff (rst)
    pos < total);
  a_r8_pos_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pos));
  a_r3_sync_leads: assert property (@(posedge clk) disable iff (rst)
    in_sync |-> !in_act);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int HSW_W = 6,
  parameter int HBP_W = 8,
  parameter int PPL_W = 10,
  parameter int HFP_W = 8,
  parameter int VSW_W = 6,
  parameter int VBP_W = 8,
  parameter int LPF_W = 10,
  parameter int VFP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PCD_W-1:0] cfg_pcd,
  input  logic             cfg_dbl_pix,
  input  logic             cfg_passive,
  input  logic [HSW_W-1:0] cfg_hsw,
  input  logic [HBP_W-1:0] cfg_hbp,
  input  logic [PPL_W-1:0] cfg_ppl,
  input  logic [HFP_W-1:0] cfg_hfp,
  input  logic [VSW_W-1:0] cfg_vsw,
  input  logic [VBP_W-1:0] cfg_vbp,
  input  logic [LPF_W-1:0] cfg_lpf,
  input  logic [VFP_W-1:0] cfg_vfp,
  output logic             pix_en_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o
);
  // shadow copy, refreshed only at reset and frame end
  logic [PCD_W-1:0] sh_pcd;
  logic             sh_dbl;
  lcd_mode_e        sh_mode;
  logic [HSW_W-1:0] sh_hsw;
  logic [HBP_W-1:0] sh_hbp;
  logic [PPL_W-1:0] sh_ppl;
  logic [HFP_W-1:0] sh_hfp;
  logic [VSW_W-1:0] sh_vsw;
  logic [VBP_W-1:0] sh_vbp;
  logic [LPF_W-1:0] sh_lpf;
  logic [VFP_W-1:0] sh_vfp;

  logic pix_en;
  logic h_last, h_sync, h_act, h_first;
  logic v_last, v_sync, v_act, v_first;
  logic line_step, frame_wrap;

  assign line_step  = pix_en & h_last;
  assign frame_wrap = line_step & v_last;

  always_ff @(posedge clk) begin
    if (rst || frame_wrap) begin
      sh_pcd  <= cfg_pcd;
      sh_dbl  <= cfg_dbl_pix;
      sh_mode <= lcd_mode_e'(cfg_passive);
      sh_hsw  <= cfg_hsw;
      sh_hbp  <= cfg_hbp;
      sh_ppl  <= cfg_ppl;
      sh_hfp  <= cfg_hfp;
      sh_vsw  <= cfg_vsw;
      sh_vbp  <= cfg_vbp;
      sh_lpf  <= cfg_lpf;
      sh_vfp  <= cfg_vfp;
    end
  end

  lcd_tg_div u_div (
    .clk    (clk),
    .rst    (rst),
    .pcd    (sh_pcd),
    .dbl    (sh_dbl),
    .pix_en (pix_en)
  );

  lcd_tg_axis #(.SW(HSW_W), .BW(HBP_W), .AW(PPL_W), .FW(HFP_W)) u_h (
    .clk       (clk),
    .rst       (rst),
    .step      (pix_en),
    .sync_m1   (sh_hsw),
    .back_n    (sh_hbp),
    .act_m1    (sh_ppl),
    .front_n   (sh_hfp),
    .last      (h_last),
    .in_sync   (h_sync),
    .in_act    (h_act),
    .act_first (h_first)
  );

  lcd_tg_axis #(.SW(VSW_W), .BW(VBP_W), .AW(LPF_W), .FW(VFP_W)) u_v (
    .clk       (clk),
    .rst       (rst),
    .step      (line_step),
    .sync_m1   (sh_vsw),
    .back_n    (sh_vbp),
    .act_m1    (sh_lpf),
    .front_n   (sh_vfp),
    .last      (v_last),
    .in_sync   (v_sync),
    .in_act    (v_act),
    .act_first (v_first)
  );

  logic unused_h_first;
  assign unused_h_first = h_first;

  assign pix_en_o = pix_en & ~rst;
  assign hsync_o  = h_sync & ~rst;
  assign vsync_o  = ~rst & ((sh_mode == MODE_PASSIVE) ? v_first : v_sync);
  assign de_o     = ~rst & h_act & v_act;

  a_r8_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !frame_wrap |=> $stable({sh_pcd, sh_dbl, sh_hsw, sh_hbp, sh_ppl, sh_hfp,
                             sh_vsw, sh_vbp, sh_lpf, sh_vfp}));
  a_r7_passive_no_sync_vs: assert property (@(posedge clk) disable iff (rst)
    (sh_mode == MODE_PASSIVE && vsync_o) |-> !v_sync);
  a_r5_de_outside_hsync: assert property (@(posedge clk) disable iff (rst)
    de_o |-> !hsync_o);
  a_r6_active_vs_no_de: assert property (@(posedge clk) disable iff (rst)
    (sh_mode == MODE_ACTIVE && vsync_o) |-> !de_o);
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |-> !(pix_en_o || hsync_o || vsync_o || de_o));
endmodule

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg_pcd = '0;
  logic cfg_dbl_pix = 1'b0, cfg_passive = 1'b0;
  logic [5:0] cfg_hsw = '0, cfg_vsw = '0;
  logic [7:0] cfg_hbp = '0, cfg_hfp = '0, cfg_vbp = '0, cfg_vfp = '0;
  logic [9:0] cfg_ppl = '0, cfg_lpf = '0;
  logic pix_en_o, hsync_o, vsync_o, de_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_timing_gen dut (
    .clk(clk), .rst(rst), .cfg_pcd(cfg_pcd), .cfg_dbl_pix(cfg_dbl_pix),
    .cfg_passive(cfg_passive), .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp),
    .cfg_ppl(cfg_ppl), .cfg_hfp(cfg_hfp), .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp),
    .cfg_lpf(cfg_lpf), .cfg_vfp(cfg_vfp), .pix_en_o(pix_en_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  bit rnd_en = 0;

  // model state: shadow configuration, pixel index in frame, cycles since pulse
  int m_pcd, m_dbl, m_pas, m_hsw, m_hbp, m_ppl, m_hfp, m_vsw, m_vbp, m_lpf, m_vfp;
  int k, g;

  function automatic int exp_period(int pcd, int dbl);
    int n = (dbl != 0 && pcd == 0) ? 1 : pcd;
    return 2 * n + 2;
  endfunction

  function automatic int span(int sync_m1, int back, int act_m1, int front);
    return sync_m1 + 1 + back + act_m1 + 1 + front;
  endfunction

  function automatic bit in_window(int p, int sync_m1, int back, int act_m1);
    return (p >= sync_m1 + 1 + back) && (p <= sync_m1 + 1 + back + act_m1);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      if (bad < 20)
        $display("FAIL %s at %0t: got %b expected %b (k=%0d)", req, $time, act, exp, k);
    end
  endtask

  task automatic latch_cfg();
    m_pcd = cfg_pcd; m_dbl = cfg_dbl_pix; m_pas = cfg_passive;
    m_hsw = cfg_hsw; m_hbp = cfg_hbp; m_ppl = cfg_ppl; m_hfp = cfg_hfp;
    m_vsw = cfg_vsw; m_vbp = cfg_vbp; m_lpf = cfg_lpf; m_vfp = cfg_vfp;
  endtask

  task automatic rand_cfg();
    cfg_pcd = 8'($urandom % 4);   cfg_dbl_pix = 1'($urandom % 2);
    cfg_passive = 1'($urandom % 2);
    cfg_hsw = 6'($urandom % 4);   cfg_hbp = 8'($urandom % 4);
    cfg_ppl = 10'($urandom % 16); cfg_hfp = 8'($urandom % 4);
    cfg_vsw = 6'($urandom % 4);   cfg_vbp = 8'($urandom % 4);
    cfg_lpf = 10'($urandom % 8);  cfg_vfp = 8'($urandom % 4);
  endtask

  // R9: outputs quiet in reset; release restarts frame with current cfg
  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 pix_en", pix_en_o, 1'b0);
      chk("R9 hsync", hsync_o, 1'b0);
      chk("R9 vsync", vsync_o, 1'b0);
      chk("R9 de", de_o, 1'b0);
    end
    rst = 1'b0;
    latch_cfg();
    k = 0; g = 1;
  endtask

  task automatic tick();
    int L, F, x, ln, per;
    bit ehs, eva, eha, evs, epe;
    @(negedge clk);
    // R8: configuration moves mid-frame; model only picks it up at frame end
    if (rnd_en && ($urandom % 150) == 0) rand_cfg();
    L = span(m_hsw, m_hbp, m_ppl, m_hfp);
    F = span(m_vsw, m_vbp, m_lpf, m_vfp);
    x = k % L; ln = k / L;
    per = exp_period(m_pcd, m_dbl);
    ehs = (x <= m_hsw);
    eha = in_window(x, m_hsw, m_hbp, m_ppl);
    eva = in_window(ln, m_vsw, m_vbp, m_lpf);
    evs = (m_pas != 0) ? (ln == m_vsw + 1 + m_vbp) : (ln <= m_vsw);
    g++;
    epe = (g == per);
    chk((m_dbl != 0 && m_pcd == 0) ? "R2 pix_en period" : "R1 pix_en period", pix_en_o, epe);
    chk("R3 hsync (R8 shadow)", hsync_o, ehs);
    chk("R4 R5 de window", de_o, eha && eva);
    chk((m_pas != 0) ? "R7 passive vsync" : "R6 active vsync", vsync_o, evs);
    if (epe) begin
      g = 0;
      if (k == L * F - 1) begin k = 0; latch_cfg(); end
      else k++;
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    void'($urandom(32'h1CD5));
    // minimal geometry, fastest divisor (R1, R3..R6)
    do_reset(); run(60);
    // double pixel mode with zero divisor (R2)
    cfg_dbl_pix = 1'b1; cfg_hsw = 6'd1; cfg_hbp = 8'd2; cfg_ppl = 10'd5; cfg_hfp = 8'd1;
    cfg_vsw = 6'd1; cfg_vbp = 8'd1; cfg_lpf = 10'd3; cfg_vfp = 8'd2;
    do_reset(); run(1500);
    // passive mode (R7)
    cfg_dbl_pix = 1'b0; cfg_passive = 1'b1; cfg_pcd = 8'd1; cfg_vsw = 6'd2;
    do_reset(); run(3000);
    // largest divisor, minimal frame (R1)
    cfg_passive = 1'b0; cfg_pcd = 8'd255;
    cfg_hsw = '0; cfg_hbp = '0; cfg_ppl = '0; cfg_hfp = '0;
    cfg_vsw = '0; cfg_vbp = '0; cfg_lpf = '0; cfg_vfp = '0;
    do_reset(); run(2600);
    // random configurations with mid-frame changes (R8)
    rand_cfg(); do_reset();
    rnd_en = 1; run(60000); rnd_en = 0;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule